// File: doc/BRIEF.md
# TDM Audio Frame Serializer

This block is the transmit engine of a serial audio port. It takes parallel PCM samples from a valid/ready stream and shifts them out one bit at a time. Frames are divided into time slots. Alongside the data it drives a frame-sync line and a bit clock. Each serial bit lasts two cycles of `clk`. In the first cycle `sck` sits at its idle level and in the second cycle it shows the opposite level, so the receiver samples on the edge in the middle of the bit.

Every part of the framing is its own input: frame length, frame-sync width, polarity and early placement, slot count, slot size, sample size, per-slot enables, first-bit offset, clock inversion and mono repeat. One engine therefore covers I2S, left- and right-justified and DSP-style TDM formats. Software chooses the field values and holds them steady while `en` is high. Raising `en` with a legal configuration starts the engine with one lead-in bit, after which frames repeat until `en` falls.

Top module: `tdm_frame_tx`

## Requirements
- R1: `cfg_err` is high when `data_size` is not in 2..7, when `slot_size` is 3, or when the sample is wider than the slot. While it is high the engine stays idle: `sd` low, `fs` at its inactive level, `sck` equal to `sck_inv`, `s_ready` low.
- R2: `data_size` selects the sample width: 2→8, 3→10, 4→16, 5→20, 6→24, 7→32 bits. The sample is taken from the low bits of `s_data` and the upper bits are ignored.
- R3: `slot_size` selects the slot width: 0 gives a slot as wide as the sample, 1 gives 16 bits, 2 gives 32 bits.
- R4: A frame has `slot_num`+1 slots and `frame_len`+1 bit periods. Bit positions beyond the last slot are driven low.
- R5: Without `fs_early`, the frame sync is active on frame bits 0 to `fs_len`. With `fs_early`, it is active from the bit before bit 0 through bit `fs_len`-1, which includes the lead-in bit. Active level is high when `fs_pol`=1 and low when `fs_pol`=0.
- R6: Slot k carries data only when bit k of `slot_mask` is set. A disabled slot is driven low and consumes no sample.
- R7: Samples leave MSB first, starting at bit `first_bit` of the slot. Slot bits before the sample and after its LSB are low. Any sample bits that would fall past the end of the slot are dropped.
- R8: When `mono`=1 and `slot_num`=1, slot 1 repeats the sample of slot 0, and only one sample is consumed per frame. With any other slot count, `mono` has no effect.
- R9: `sck` equals `sck_inv` during the first cycle of each bit and its inverse during the second cycle. `sd` and `fs` change only at bit boundaries.
- R10: `s_ready` is high while running when the one-entry holding register is empty, or when that register is being emptied into a slot in the same cycle. If an enabled slot starts with no sample held, that slot is sent as zeros.
- R11: After `en` rises with a legal configuration, one lead-in bit with `sd` low comes before frame bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; two cycles per serial bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low returns the engine to idle |
| frame_len | input | FRAME_W | Bit periods per frame minus one |
| fs_len | input | FRAME_W | Active frame-sync bits minus one |
| fs_pol | input | 1 | 1: frame sync active high |
| fs_early | input | 1 | Frame sync starts one bit before slot 0 |
| slot_num | input | SLOT_CNT_W | Slots per frame minus one |
| slot_size | input | 2 | Slot width code |
| data_size | input | 3 | Sample width code |
| slot_mask | input | 2**SLOT_CNT_W | Per-slot enable |
| first_bit | input | 5 | Slot bit holding the sample MSB |
| sck_inv | input | 1 | Inverts the bit clock |
| mono | input | 1 | Repeat slot 0 in slot 1 for two-slot frames |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Sample accepted when high with `s_valid` |
| s_data | input | SAMPLE_W | Sample, right-aligned |
| sd | output | 1 | Serial data |
| fs | output | 1 | Frame sync |
| sck | output | 1 | Bit clock |
| cfg_err | output | 1 | Configuration illegal |

## Verification
Two things can happen on the same clock edge: the holding register can be emptied into a newly starting slot, and a new sample can be accepted into it. The bench provokes this by holding `s_valid` high for the whole run, with the sample value advancing on every observed acceptance. The result is judged by checking every slot of every frame against the arithmetic model, so a dropped, duplicated or late sample shows up as wrong bits in the slot where it was expected. A second run holds `s_valid` low, and the model then expects every enabled slot to be empty.

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx #(
  parameter int SLOT_CNT_W = 4,
  parameter int FRAME_W    = 9,
  parameter int SAMPLE_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [FRAME_W-1:0]         frame_len,
  input  logic [FRAME_W-1:0]         fs_len,
  input  logic                       fs_pol,
  input  logic                       fs_early,
  input  logic [SLOT_CNT_W-1:0]      slot_num,
  input  logic [1:0]                 slot_size,
  input  logic [2:0]                 data_size,
  input  logic [(1<<SLOT_CNT_W)-1:0] slot_mask,
  input  logic [$clog2(SAMPLE_W)-1:0] first_bit,
  input  logic                       sck_inv,
  input  logic                       mono,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [SAMPLE_W-1:0]        s_data,
  output logic                       sd,
  output logic                       fs,
  output logic                       sck,
  output logic                       cfg_err
);
  localparam int MAX_SLOTS = 1 << SLOT_CNT_W;
  localparam int IDX_W     = SLOT_CNT_W + 1;
  localparam int POS_W     = $clog2(SAMPLE_W) + 1;

  logic [POS_W-1:0] dbits, sbits;
  always_comb begin
    case (data_size)
      3'd2:    dbits = POS_W'(8);
      3'd3:    dbits = POS_W'(10);
      3'd4:    dbits = POS_W'(16);
      3'd5:    dbits = POS_W'(20);
      3'd6:    dbits = POS_W'(24);
      3'd7:    dbits = POS_W'(32);
      default: dbits = '0;
    endcase
    case (slot_size)
      2'd0:    sbits = dbits;
      2'd1:    sbits = POS_W'(16);
      2'd2:    sbits = POS_W'(32);
      default: sbits = '0;
    endcase
  end

  wire cfg_ok = (dbits != '0) && (sbits != '0) && (dbits <= sbits);
  assign cfg_err = !cfg_ok;

  logic                running, lead, phase, cur_live, hold_v;
  logic [FRAME_W-1:0]  bitpos;
  logic [POS_W-1:0]    slot_bit;
  logic [IDX_W-1:0]    slot_idx;
  logic [SAMPLE_W-1:0] cur, hold;

  wire [IDX_W-1:0] nslots   = {1'b0, slot_num} + IDX_W'(1);
  wire             mono_on  = mono && (slot_num == SLOT_CNT_W'(1));
  wire             adv      = running && phase;
  wire             wrap     = lead || (bitpos == frame_len);
  wire             slot_end = (slot_bit == sbits - POS_W'(1));
  wire             new_slot = wrap || slot_end;

  logic [IDX_W-1:0] nxt_slot;
  always_comb begin
    if (wrap)                                   nxt_slot = '0;
    else if (slot_end && slot_idx != IDX_W'(MAX_SLOTS)) nxt_slot = slot_idx + IDX_W'(1);
    else                                        nxt_slot = slot_idx;
  end

  wire slot_live = (nxt_slot < nslots) && slot_mask[nxt_slot[SLOT_CNT_W-1:0]];
  wire repeat_0  = mono_on && (nxt_slot == IDX_W'(1));
  wire take      = adv && new_slot && slot_live && !repeat_0;
  wire accept    = s_valid && s_ready;

  assign s_ready = running && (!hold_v || take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; lead <= 1'b1; phase <= 1'b0; cur_live <= 1'b0;
      hold_v <= 1'b0; bitpos <= '0; slot_bit <= '0; slot_idx <= '0;
      cur <= '0; hold <= '0;
    end else if (!(en && cfg_ok)) begin
      running <= 1'b0; lead <= 1'b1; phase <= 1'b0; cur_live <= 1'b0;
      hold_v <= 1'b0; bitpos <= '0; slot_bit <= '0; slot_idx <= '0;
      cur <= '0;
    end else begin
      running <= 1'b1;
      phase   <= running ? !phase : 1'b0;
      if (accept) hold <= s_data;
      hold_v  <= take ? accept : (hold_v || accept);
      if (adv) begin
        lead     <= 1'b0;
        bitpos   <= wrap ? '0 : bitpos + FRAME_W'(1);
        slot_bit <= new_slot ? '0 : slot_bit + POS_W'(1);
        if (new_slot) begin
          slot_idx <= nxt_slot;
          cur_live <= slot_live;
          if (!slot_live)    cur <= '0;
          else if (!repeat_0) cur <= hold_v ? hold : '0;
        end
      end
    end
  end

  wire [POS_W-1:0] fb_ext = {1'b0, first_bit};
  wire [POS_W-1:0] rel    = slot_bit - fb_ext;
  wire             in_win = (slot_bit >= fb_ext) && (rel < dbits);
  wire [POS_W-1:0] pick   = dbits - POS_W'(1) - rel;
  wire             bit_v  = |(cur & (SAMPLE_W'(1) << pick));

  assign sd = running && !lead && cur_live && in_win && bit_v;

  wire fs_win = lead ? fs_early
              : (fs_early ? ((bitpos == frame_len) || (bitpos < fs_len))
                          : (bitpos <= fs_len));
  wire fs_act = running && fs_win;
  assign fs  = fs_pol ? fs_act : !fs_act;
  assign sck = (running && phase) ^ sck_inv;

  assert_err_stops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !running);
  assert_lead_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (running && lead) |-> !sd);
  assert_dead_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !cur_live) |-> !sd);
  assert_bit_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && phase && $past(running)) |-> ($stable(sd) && $stable(fs)));
  assert_sample_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && en && cfg_ok) |=> hold_v);
endmodule

// File: tb/sim_tdm_frame_tx.sv
module sim_tdm_frame_tx;
  logic clk = 0, rst_n = 0, en = 0;
  logic [8:0] frame_len = 0, fs_len = 0;
  logic fs_pol = 1, fs_early = 0, sck_inv = 0, mono = 0, s_valid = 0;
  logic [3:0] slot_num = 0;
  logic [1:0] slot_size = 0;
  logic [2:0] data_size = 2;
  logic [15:0] slot_mask = 0;
  logic [4:0] first_bit = 0;
  logic [31:0] s_data = 0;
  logic s_ready, sd, fs, sck, cfg_err;
  int checks = 0, errors = 0;

  always #10 clk = !clk;

  tdm_frame_tx u0 (.clk(clk), .rst_n(rst_n), .en(en), .frame_len(frame_len),
    .fs_len(fs_len), .fs_pol(fs_pol), .fs_early(fs_early), .slot_num(slot_num),
    .slot_size(slot_size), .data_size(data_size), .slot_mask(slot_mask),
    .first_bit(first_bit), .sck_inv(sck_inv), .mono(mono), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .sd(sd), .fs(fs), .sck(sck), .cfg_err(cfg_err));

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, got, exp);
    end
  endtask

  function automatic int dsz(input int c);
    case (c) 2: return 8; 3: return 10; 4: return 16; 5: return 20; 6: return 24; 7: return 32;
      default: return 0; endcase
  endfunction

  function automatic logic [31:0] pat(input int n);
    return (32'h9E3779B9 * (n + 1)) ^ (n << 7) ^ 32'h0F0F_3C3C;
  endfunction

  task automatic run_cfg(input string tag, input int nb, input int ss, input int ds,
      input logic [15:0] mask, input int fb, input int fsl, input int frl,
      input bit pol, input bit early, input bit inv, input bit mo, input bit vld,
      input int frames);
    int d, w, ns, seq, idx, bp, sl, b, bit_i, ph;
    bit prev_acc, live, act, exp_sd;
    logic [31:0] cur_exp;
    string t;
    @(negedge clk);
    en = 0;
    repeat (2) @(negedge clk);
    slot_num = 4'(nb); slot_size = 2'(ss); data_size = 3'(ds); slot_mask = mask;
    first_bit = 5'(fb); fs_len = 9'(fsl); frame_len = 9'(frl); fs_pol = pol;
    fs_early = early; sck_inv = inv; mono = mo; s_valid = vld;
    d = dsz(ds); w = (ss == 0) ? d : (ss == 1 ? 16 : 32); ns = nb + 1;
    seq = 0; idx = 0; prev_acc = 0; live = 0; cur_exp = 0;
    s_data = pat(0);
    @(negedge clk);
    en = 1;
    @(posedge clk);
    for (int c = 0; c < 2 * (frames * (frl + 1) + 1); c++) begin
      @(negedge clk);
      if (prev_acc) begin seq++; s_data = pat(seq); end
      prev_acc = s_valid && s_ready;
      bit_i = c / 2 - 1; ph = c % 2;
      if (bit_i < 0) begin
        act = early; exp_sd = 0; t = "R11";
      end else begin
        bp = bit_i % (frl + 1); sl = bp / w; b = bp % w;
        if (ph == 0 && b == 0) begin
          live = (sl < ns) && mask[sl];
          if (live && !(mo && nb == 1 && sl == 1)) begin
            cur_exp = vld ? pat(idx) : 32'h0; idx++;
          end
        end
        act = early ? (bp == frl || bp < fsl) : (bp <= fsl);
        exp_sd = (live && b >= fb && b - fb < d) ? cur_exp[d - 1 - (b - fb)] : 1'b0;
        t = tag;
      end
      chk(sd, exp_sd, t);
      chk(fs, pol ? act : !act, "R5");
      chk(sck, 1'(ph) ^ inv, "R9");
    end
    @(negedge clk);
    en = 0;
  endtask

  task automatic err_cfg(input int ss, input int ds, input bit exp_err);
    @(negedge clk);
    en = 0; slot_size = 2'(ss); data_size = 3'(ds); slot_num = 1; slot_mask = 16'h3;
    frame_len = 31; fs_len = 15; fs_pol = 1; sck_inv = 1; s_valid = 1;
    @(negedge clk);
    en = 1;
    repeat (3) @(negedge clk);
    chk(cfg_err, exp_err, "R1");
    if (exp_err) begin
      chk(sd, 1'b0, "R1"); chk(fs, 1'b0, "R1");
      chk(sck, 1'b1, "R1"); chk(s_ready, 1'b0, "R1");
    end
    en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sd, 1'b0, "R11"); chk(fs, 1'b0, "R5"); chk(sck, 1'b0, "R9"); chk(s_ready, 1'b0, "R10");
    rst_n = 1;
    // R1 illegal and legal codes
    err_cfg(0, 1, 1);
    err_cfg(3, 4, 1);
    err_cfg(1, 6, 1);
    err_cfg(1, 4, 0);
    // R2 every sample width, slot sized to sample
    for (int c = 2; c <= 7; c++)
      run_cfg("R2", 1, 0, c, 16'h3, 0, dsz(c) - 1, 2 * dsz(c) - 1, 1, 0, 0, 0, 1, 2);
    // R3 fixed slot widths with short samples
    run_cfg("R3", 1, 1, 2, 16'h3, 0, 15, 31, 1, 1, 0, 0, 1, 2);
    run_cfg("R3", 1, 2, 3, 16'h3, 0, 31, 63, 0, 0, 1, 0, 1, 2);
    // R7 right-justified 20-bit in 32-bit slot, and a truncating offset
    run_cfg("R7", 1, 2, 5, 16'h3, 12, 31, 63, 1, 0, 0, 0, 1, 2);
    run_cfg("R7", 1, 1, 2, 16'h3, 12, 15, 31, 0, 1, 1, 0, 1, 2);
    // R6 sparse mask in an 8-slot DSP frame
    run_cfg("R6", 7, 1, 3, 16'h00A5, 0, 0, 127, 1, 1, 0, 0, 1, 2);
    // R4 sixteen slots, and a frame longer than its slots
    run_cfg("R4", 15, 0, 2, 16'hFFFF, 0, 0, 127, 1, 0, 0, 0, 1, 2);
    run_cfg("R4", 1, 0, 2, 16'h3, 0, 11, 23, 1, 0, 0, 0, 1, 3);
    run_cfg("R4", 0, 2, 7, 16'h1, 0, 15, 31, 0, 1, 1, 0, 1, 2);
    // R8 mono repeat, and mono ignored with four slots
    run_cfg("R8", 1, 2, 6, 16'h3, 0, 31, 63, 1, 0, 0, 1, 1, 3);
    run_cfg("R8", 3, 0, 4, 16'hF, 0, 31, 63, 1, 0, 0, 1, 1, 2);
    // R10 no samples offered: every slot empty
    run_cfg("R10", 1, 0, 4, 16'h3, 0, 15, 31, 0, 1, 1, 0, 0, 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule